// File: doc/BRIEF.md
# Boot Destination Control Register

This block is a 32-bit control register combined with the address decoder that steers boot firmware memory cycles. When power-good rises, two strap pins are loaded into a 2-bit destination field. Firmware can later rewrite that field until it sets a sticky lock-down bit. The register also holds three other fields:

- a plain error-reporting mode bit, which drives an output;
- a write-once lock that freezes one bit held in a neighbouring register, modelled here as a single stored bit;
- the lock-down bit itself.

Each incoming 32-bit memory address is classified into exactly one registered route: SPI flash, PCI, LPC or none. In PCI mode every address in the top 16 MB below 4 GB goes to PCI, whatever the per-interface decode enables say. In SPI or LPC mode a window hit is routed only when the decode enable of that interface is high. The reserved encoding routes nothing.

Top module: `boot_route_ctl`

## Requirements
- R1: After a cycle with `rst` high, `cfg_rdata` reads 0, `nbr_bit` is 0, `err_mode` is 0 and `rt_none` is 1 with the other routes at 0.
- R2: On the first clock where `pwr_good` is high after being low, the destination field `cfg_rdata[11:10]` is loaded from `{strap_hi, strap_lo}`, visible one cycle later. This happens even when the field is locked. Straps that change while `pwr_good` stays high are not sampled.
- R3: Destination encoding in `cfg_rdata[11:10]`: 00 reserved, 01 SPI, 10 PCI, 11 LPC.
- R4: A `cfg_wr` loads `cfg_wdata[11:10]` into the destination field only if the lock-down bit (bit 0) was clear before that write. A write that sets bit 0 therefore still updates the field in the same write.
- R5: Lock-down bit 0 is set by a write with `cfg_wdata[0]`=1. A write of 0 leaves it set, and so do `sleep_exit` and a power-good edge. Only `rst` clears it.
- R6: Bit 9 is freely written by every `cfg_wr`, reads back, and drives `err_mode`.
- R7: Bit 7 is set by a write with `cfg_wdata[7]`=1 and cannot be cleared by writes. While it is set, `nbr_wr` leaves `nbr_bit` unchanged. While it is clear, `nbr_wr` loads `nbr_wdata` into `nbr_bit`.
- R8: Bit 7 is cleared by `rst` and by `sleep_exit`. If `sleep_exit` and a write setting bit 7 arrive in the same cycle, bit 7 ends up clear.
- R9: With destination 10, an address whose top byte is FFh gives `rt_pci` one cycle later, regardless of `spi_dec_en` and `lpc_dec_en`. Any other address gives `rt_none`.
- R10: With destination 01 or 11, a window hit (top byte FFh) gives `rt_spi` or `rt_lpc` only while `spi_dec_en` or `lpc_dec_en` respectively is high. In every other case the route is `rt_none`. Destination 00 always gives `rt_none`.
- R11: Bits 31:12, 8 and 6:1 of `cfg_rdata` always read 0, whatever is written.
- R12: Exactly one of `rt_spi`, `rt_pci`, `rt_lpc`, `rt_none` is high in every cycle. Each route is registered and reflects the address and enables of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| pwr_good | input | 1 | Power-good level; its rising edge samples the straps |
| strap_hi | input | 1 | Strap for destination bit 11 |
| strap_lo | input | 1 | Strap for destination bit 10 |
| sleep_exit | input | 1 | Pulse on return from a deep sleep state |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read value |
| nbr_wr | input | 1 | Write strobe for the protected neighbour bit |
| nbr_wdata | input | 1 | Data for the protected neighbour bit |
| nbr_bit | output | 1 | Protected neighbour bit |
| err_mode | output | 1 | Error-reporting mode bit |
| mem_addr | input | 32 | Memory address to classify |
| spi_dec_en | input | 1 | SPI firmware-range decode enable |
| lpc_dec_en | input | 1 | LPC firmware-range decode enable |
| rt_spi | output | 1 | Route to SPI flash |
| rt_pci | output | 1 | Route to PCI |
| rt_lpc | output | 1 | Route to LPC |
| rt_none | output | 1 | No route |

## Verification
Two pairs of events can land on the same clock edge. In the first, a register write that sets the neighbour lock arrives together with `sleep_exit`. The bench drives both in one cycle and expects bit 7 clear, after which a neighbour write must take effect. In the second, a write sets lock-down and carries a new destination at once. The bench expects the new destination to land and a later write of a different destination to be refused. Routing is swept over every destination code, every enable pair, and addresses at both window edges, just below the window and far from it. Each route is compared with a value the bench computes from the address.

// File: rtl/boot_route_pkg.sv
package boot_route_pkg;
  localparam int REG_W   = 32;
  localparam int POS_LKD = 0;   // lock-down of destination field
  localparam int POS_NLK = 7;   // write-once neighbour lock
  localparam int POS_ERR = 9;   // error-reporting mode
  localparam int POS_DST = 10;  // 2-bit destination field
  localparam int DST_W   = 2;

  typedef enum logic [DST_W-1:0] {
    DST_RSVD = 2'b00,
    DST_SPI  = 2'b01,
    DST_PCI  = 2'b10,
    DST_LPC  = 2'b11
  } dest_e;

  typedef struct packed {
    logic spi;
    logic pci;
    logic lpc;
    logic none;
  } route_t;
endpackage

// File: rtl/brc_ctl_reg.sv
module brc_ctl_reg
  import boot_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic             strap_hi,
  input  logic             strap_lo,
  input  logic             sleep_exit,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output dest_e            dest,
  output logic             nbr_lock,
  output logic             err_mode,
  output logic [REG_W-1:0] rd_data
);
  logic pg_q;
  logic lock_dn;
  logic pg_rise;
  logic unused_wbits;

  assign pg_rise      = pwr_good & ~pg_q;
  assign unused_wbits = ^{wdata[REG_W-1:POS_DST+DST_W], wdata[POS_ERR-1:POS_NLK+1],
                          wdata[POS_NLK-1:POS_LKD+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q     <= 1'b0;
      dest     <= DST_RSVD;
      lock_dn  <= 1'b0;
      nbr_lock <= 1'b0;
      err_mode <= 1'b0;
    end else begin
      pg_q <= pwr_good;
      if (wr_en) begin
        err_mode <= wdata[POS_ERR];
        if (wdata[POS_LKD]) lock_dn <= 1'b1;
        if (wdata[POS_NLK]) nbr_lock <= 1'b1;
        if (!lock_dn) dest <= dest_e'(wdata[POS_DST +: DST_W]);
      end
      if (pg_rise)    dest     <= dest_e'({strap_hi, strap_lo});
      if (sleep_exit) nbr_lock <= 1'b0;
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[POS_LKD]           = lock_dn;
    rd_data[POS_NLK]           = nbr_lock;
    rd_data[POS_ERR]           = err_mode;
    rd_data[POS_DST +: DST_W]  = dest;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_dn |=> lock_dn); // R5
  AST_DEST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (lock_dn && !pg_rise) |=> $stable(dest)); // R4
  AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sleep_exit |=> !nbr_lock); // R8
endmodule

// File: rtl/brc_nbr_bit.sv
module brc_nbr_bit (
  input  logic clk,
  input  logic rst,
  input  logic lock,
  input  logic wr,
  input  logic wdata,
  output logic bit_q
);
  always_ff @(posedge clk) begin
    if (rst)             bit_q <= 1'b0;
    else if (wr && !lock) bit_q <= wdata;
  end

  AST_NBR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(bit_q)); // R7
endmodule

// File: rtl/brc_route.sv
module brc_route
  import boot_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dest_e             dest,
  input  logic [ADDR_W-1:0] addr,
  input  logic              spi_en,
  input  logic              lpc_en,
  output route_t            route
);
  localparam int LOW_W = ADDR_W - WIN_W;

  logic   hit;
  logic   unused_low;
  route_t nxt;

  assign hit        = &addr[ADDR_W-1 -: WIN_W];
  assign unused_low = ^addr[LOW_W-1:0];

  always_comb begin
    nxt = '0;
    unique case (dest)
      DST_PCI:  nxt.pci = hit;
      DST_SPI:  nxt.spi = hit & spi_en;
      DST_LPC:  nxt.lpc = hit & lpc_en;
      default:  ;
    endcase
    nxt.none = ~(nxt.pci | nxt.spi | nxt.lpc);
  end

  always_ff @(posedge clk) begin
    if (rst) route <= '{spi: 1'b0, pci: 1'b0, lpc: 1'b0, none: 1'b1};
    else     route <= nxt;
  end

  AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(route) == 1); // R12
  AST_PCI_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (dest == DST_PCI && hit) |=> route.pci); // R9
  AST_RSVD_NONE: assert property (@(posedge clk) disable iff (rst)
    (dest == DST_RSVD) |=> route.none); // R10
endmodule

// File: rtl/boot_route_ctl.sv
module boot_route_ctl
  import boot_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic              strap_hi,
  input  logic              strap_lo,
  input  logic              sleep_exit,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              nbr_wr,
  input  logic              nbr_wdata,
  output logic              nbr_bit,
  output logic              err_mode,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              spi_dec_en,
  input  logic              lpc_dec_en,
  output logic              rt_spi,
  output logic              rt_pci,
  output logic              rt_lpc,
  output logic              rt_none
);
  dest_e  dest;
  logic   nbr_lock;
  route_t route;

  brc_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .strap_hi(strap_hi),
    .strap_lo(strap_lo), .sleep_exit(sleep_exit), .wr_en(cfg_wr),
    .wdata(cfg_wdata), .dest(dest), .nbr_lock(nbr_lock),
    .err_mode(err_mode), .rd_data(cfg_rdata)
  );

  brc_nbr_bit u_nbr (
    .clk(clk), .rst(rst), .lock(nbr_lock), .wr(nbr_wr),
    .wdata(nbr_wdata), .bit_q(nbr_bit)
  );

  brc_route #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_route (
    .clk(clk), .rst(rst), .dest(dest), .addr(mem_addr),
    .spi_en(spi_dec_en), .lpc_en(lpc_dec_en), .route(route)
  );

  assign rt_spi  = route.spi;
  assign rt_pci  = route.pci;
  assign rt_lpc  = route.lpc;
  assign rt_none = route.none;
endmodule

// File: tb/boot_route_ctl_tb.sv
module boot_route_ctl_tb;
  logic        clk = 0;
  logic        rst, pwr_good, strap_hi, strap_lo, sleep_exit;
  logic        cfg_wr, nbr_wr, nbr_wdata, spi_dec_en, lpc_dec_en;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr;
  logic        nbr_bit, err_mode, rt_spi, rt_pci, rt_lpc, rt_none;

  int checks = 0;
  int errors = 0;

  // bench model of register state
  logic [1:0] m_dst;
  logic       m_lk0, m_lk7, m_err, m_nbr;

  always #5 clk = ~clk;

  boot_route_ctl u_dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .strap_hi(strap_hi),
    .strap_lo(strap_lo), .sleep_exit(sleep_exit), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .nbr_wr(nbr_wr),
    .nbr_wdata(nbr_wdata), .nbr_bit(nbr_bit), .err_mode(err_mode),
    .mem_addr(mem_addr), .spi_dec_en(spi_dec_en), .lpc_dec_en(lpc_dec_en),
    .rt_spi(rt_spi), .rt_pci(rt_pci), .rt_lpc(rt_lpc), .rt_none(rt_none)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_reg();
    return {20'd0, m_dst, m_err, 1'b0, m_lk7, 6'd0, m_lk0};
  endfunction

  function automatic logic [3:0] m_route(input logic [1:0] d, input logic [31:0] a,
                                         input logic se, input logic le);
    logic hit;
    logic [3:0] r;
    hit = (a >= 32'hFF00_0000);
    r = 4'b0000;
    if (d == 2'b10 && hit)      r = 4'b0100;
    else if (d == 2'b01 && hit && se) r = 4'b1000;
    else if (d == 2'b11 && hit && le) r = 4'b0010;
    else r = 4'b0001;
    return r;
  endfunction

  task automatic do_reset();
    rst = 1; tick(); rst = 0;
    m_dst = 0; m_lk0 = 0; m_lk7 = 0; m_err = 0; m_nbr = 0;
  endtask

  task automatic wr(input logic [31:0] d, input logic slp);
    cfg_wr = 1; cfg_wdata = d; sleep_exit = slp;
    tick();
    cfg_wr = 0; sleep_exit = 0;
    m_err = d[9];
    if (!m_lk0) m_dst = d[11:10];
    if (d[0]) m_lk0 = 1;
    if (d[7]) m_lk7 = 1;
    if (slp)  m_lk7 = 0;
  endtask

  task automatic nwr(input logic v);
    nbr_wr = 1; nbr_wdata = v; tick(); nbr_wr = 0;
    if (!m_lk7) m_nbr = v;
  endtask

  task automatic pg_cycle(input logic [1:0] s);
    pwr_good = 0; tick();
    strap_hi = s[1]; strap_lo = s[0]; pwr_good = 1; tick();
    m_dst = s;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; pwr_good = 0; strap_hi = 0; strap_lo = 0; sleep_exit = 0;
    cfg_wr = 0; cfg_wdata = 0; nbr_wr = 0; nbr_wdata = 0;
    mem_addr = 0; spi_dec_en = 0; lpc_dec_en = 0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 rdata", cfg_rdata, 32'd0);
    chk("R1 nbr", {31'd0, nbr_bit}, 32'd0);
    chk("R1 err", {31'd0, err_mode}, 32'd0);
    chk("R1 route", {28'd0, rt_spi, rt_pci, rt_lpc, rt_none}, 32'd1);

    // R2 strap capture for every strap pair, R3 encoding position
    for (int s = 0; s < 4; s++) begin
      pg_cycle(s[1:0]);
      chk("R2 capture", cfg_rdata, m_reg());
      strap_hi = ~s[1]; strap_lo = ~s[0]; tick();
      chk("R2 no resample while high", cfg_rdata, m_reg());
    end

    // R9 R10 R3 routing sweep
    for (int d = 0; d < 4; d++) begin
      wr({20'd0, d[1:0], 10'd0}, 0);
      chk("R3 dest write", cfg_rdata, m_reg());
      for (int e = 0; e < 4; e++) begin
        for (int k = 0; k < 5; k++) begin
          logic [31:0] a;
          case (k)
            0: a = 32'hFF00_0000;
            1: a = 32'hFFFF_FFFF;
            2: a = 32'hFEFF_FFFF;
            3: a = 32'h0000_0000;
            default: a = 32'hFF80_1234;
          endcase
          mem_addr = a; spi_dec_en = e[0]; lpc_dec_en = e[1];
          tick();
          chk((d == 2) ? "R9 pci route" : "R10 spi/lpc route",
              {28'd0, rt_spi, rt_pci, rt_lpc, rt_none},
              {28'd0, m_route(d[1:0], a, e[0], e[1])});
          chk("R12 onehot", $countones({rt_spi, rt_pci, rt_lpc, rt_none}), 32'd1);
        end
      end
    end

    // R6 error mode bit
    wr(32'h0000_0200, 0);
    chk("R6 err set", {31'd0, err_mode}, 32'd1);
    chk("R6 readback", cfg_rdata, m_reg());
    wr(32'h0000_0000, 0);
    chk("R6 err clear", {31'd0, err_mode}, 32'd0);

    // R4 R5 lock-down with a new destination in the same write
    wr(32'h0000_0401, 0);
    chk("R4 dest lands with lock write", cfg_rdata, m_reg());
    wr(32'h0000_0800, 0);
    chk("R4 dest frozen", cfg_rdata, m_reg());
    chk("R5 lock survives write 0", {31'd0, cfg_rdata[0]}, 32'd1);
    sleep_exit = 1; tick(); sleep_exit = 0;
    chk("R5 lock survives sleep", cfg_rdata, m_reg());
    pg_cycle(2'b11);
    chk("R2 strap loads while locked", cfg_rdata, m_reg());
    chk("R5 lock survives pg edge", {31'd0, cfg_rdata[0]}, 32'd1);
    do_reset();
    chk("R5 reset clears lock", cfg_rdata, 32'd0);

    // R7 R8 neighbour lock
    nwr(1);
    chk("R7 nbr write open", {31'd0, nbr_bit}, {31'd0, m_nbr});
    wr(32'h0000_0080, 0);
    chk("R7 lock set", cfg_rdata, m_reg());
    nwr(0);
    chk("R7 nbr frozen", {31'd0, nbr_bit}, 32'd1);
    wr(32'h0000_0000, 0);
    chk("R7 write 0 keeps lock", cfg_rdata, m_reg());
    sleep_exit = 1; tick(); sleep_exit = 0; m_lk7 = 0;
    chk("R8 sleep clears", cfg_rdata, m_reg());
    nwr(0);
    chk("R8 nbr writable again", {31'd0, nbr_bit}, 32'd0);
    wr(32'h0000_0080, 1);
    chk("R8 sleep beats set", cfg_rdata, m_reg());
    nwr(1);
    chk("R8 nbr writable after collision", {31'd0, nbr_bit}, 32'd1);
    wr(32'h0000_0080, 0);
    rst = 1; tick(); rst = 0;
    chk("R8 reset clears bit7", cfg_rdata, 32'd0);
    chk("R1 reset clears nbr", {31'd0, nbr_bit}, 32'd0);
    m_dst = 0; m_lk0 = 0; m_lk7 = 0; m_err = 0; m_nbr = 0;

    // R11 reserved bits
    wr(32'hFFFF_FFFF, 0);
    chk("R11 reserved zero", cfg_rdata, 32'h0000_0E81);
    wr(32'hFFFF_F17E, 0);
    chk("R11 reserved zero 2", cfg_rdata, m_reg());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule